// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Driver

This block stores one 56-bit segment pattern for each of up to four common rows and scans a segment LCD at a duty of 1/2, 1/3 or 1/4. Each tick from a divided oscillator advances the scan by half a common period. The two halves of a row use opposite polarity, so the panel never sees a net DC level. Every output pin carries a small level code, and an external analog stage turns that code into a voltage.

A host loads rows through a 2-bit address and a write strobe. The top eight segment pins can be switched to LED drive with inverted polarity. The lowest eight segment pins give way to an external key scan while it runs. A low output enable blanks the whole panel and keeps the stored patterns.

Top module: `lcd_scan_drv`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` in row `wr_addr`. Address 0 maps to `com_lv` slot 0 and address 3 maps to slot 3. The bit `j` of a row drives segment slot `j`.
- R2: `duty_sel` 01 selects 2 rows, 10 selects 3 rows, and 11 or 00 selects 4 rows. The value is sampled at the first tick after reset and again whenever the scan wraps from its last active row to row 0.
- R3: Each tick while scanning toggles the half-phase. A tick in the second half moves to the next row, and after the last active row the scan wraps to row 0.
- R4: The active row's common gets code 1 in the first half and 2 in the second half. Every other common gets 3 or 4. A row beyond the chosen duty never gets 1 or 2.
- R5: An LCD segment whose current-row bit is 1 gets 1 or 2, following the half-phase. A bit of 0 gives 3 or 4.
- R6: While `lcd_mode` is low, segment slots 48 to 55 act as LEDs. A bit of 0 gives code 6 (lit) and a bit of 1 gives code 0.
- R7: While `out_en` is low, every segment and common code is 0. When `out_en` returns high, the stored patterns are shown unchanged.
- R8: While `key_scan` is high and the panel is not blanked, segment slots 0 to 7 carry code 5 (released to key scan).
- R9: A segment pattern is loaded for display only when a row starts. A write to the row being shown does not appear until that row is next entered.
- R10: Reset clears all rows and selects 4 rows. All outputs stay at code 0 until the first tick. The outputs are registered, so they reflect the state and inputs one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Row write strobe |
| wr_addr | input | 2 | Row address for write |
| wr_data | input | 56 | Segment pattern to store |
| duty_sel | input | 2 | Duty select |
| lcd_mode | input | 1 | 1: top eight pins are LCD segments; 0: LED outputs |
| out_en | input | 1 | 0 blanks all outputs |
| key_scan | input | 1 | Key scan period in progress |
| tick | input | 1 | Half-period advance pulse |
| seg_lv | output | 168 | Segment level codes, 3 bits per slot |
| com_lv | output | 12 | Common level codes, 3 bits per slot |

## Verification
The hardest cases to reach are a write that lands on the row being displayed, and a duty change made partway through a frame. Both must wait for a boundary. The stimulus rewrites the displayed row between two ticks of the same row. It changes `duty_sel` in the middle of a frame, and it runs long bursts with a tick on every clock so that writes coincide with row loads. A behavioural model tracks the row, the phase and the held pattern, and every output code is compared with it on each clock.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int LVW = 3;

  typedef enum logic [LVW-1:0] {
    LV_OFF    = 3'd0,
    LV_SEL    = 3'd1,
    LV_SEL_N  = 3'd2,
    LV_NSEL   = 3'd3,
    LV_NSEL_N = 3'd4,
    LV_YIELD  = 3'd5,
    LV_LED_ON = 3'd6
  } lvl_t;
endpackage

// File: rtl/lcd_latch_bank.sv
module lcd_latch_bank #(
  parameter int NSEG = 56,
  parameter int NROW = 4,
  localparam int ROWW = $clog2(NROW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [ROWW-1:0] wr_addr,
  input  logic [NSEG-1:0] wr_data,
  input  logic            ld_en,
  input  logic [ROWW-1:0] ld_addr,
  output logic [NSEG-1:0] shadow
);
  logic [NSEG-1:0] mem [NROW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NROW; i++) mem[i] <= '0;
      shadow <= '0;
    end else begin
      if (wr_en) mem[wr_addr] <= wr_data;
      if (ld_en) shadow <= mem[ld_addr];
    end
  end

  // R9: the held pattern changes only at a row load
  a_r9_hold_between_rows: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(shadow));
endmodule

// File: rtl/lcd_row_seq.sv
module lcd_row_seq #(
  parameter int NROW = 4,
  localparam int ROWW = $clog2(NROW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [1:0]      duty_sel,
  output logic            running,
  output logic            half,
  output logic [ROWW-1:0] row,
  output logic            ld_en,
  output logic [ROWW-1:0] ld_addr
);
  logic [ROWW-1:0] last;

  function automatic logic [ROWW-1:0] dec_duty(input logic [1:0] d);
    case (d)
      2'b01:   return ROWW'(1);
      2'b10:   return ROWW'(2);
      default: return ROWW'(NROW - 1);
    endcase
  endfunction

  always_comb begin
    ld_en   = 1'b0;
    ld_addr = '0;
    if (tick) begin
      if (!running) begin
        ld_en = 1'b1;
      end else if (half) begin
        ld_en   = 1'b1;
        ld_addr = (row == last) ? '0 : row + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      half    <= 1'b0;
      row     <= '0;
      last    <= ROWW'(NROW - 1);
    end else if (tick) begin
      if (!running) begin
        running <= 1'b1;
        half    <= 1'b0;
        row     <= '0;
        last    <= dec_duty(duty_sel);
      end else if (!half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        row  <= ld_addr;
        if (row == last) last <= dec_duty(duty_sel);
      end
    end
  end

  // R3: the active row never passes the last row of the chosen duty
  a_r3_row_in_range: assert property (@(posedge clk) disable iff (rst)
    row <= last);
  // R3: every tick while scanning flips the half-phase
  a_r3_half_flips: assert property (@(posedge clk) disable iff (rst)
    (running && tick) |=> half != $past(half));
endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage
  import lcd_pkg::*;
#(
  parameter int NSEG = 56,
  parameter int NROW = 4,
  parameter int NLED = 8,
  parameter int NKEY = 8,
  localparam int ROWW = $clog2(NROW)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 running,
  input  logic                 half,
  input  logic [ROWW-1:0]      row,
  input  logic [NSEG-1:0]      shadow,
  input  logic                 out_en,
  input  logic                 lcd_mode,
  input  logic                 key_scan,
  output logic [NSEG*LVW-1:0]  seg_q,
  output logic [NROW*LVW-1:0]  com_q
);
  lvl_t on_lv, off_lv;
  logic blank;
  lvl_t seg_d [NSEG];
  lvl_t com_d [NROW];

  assign blank  = !out_en || !running;
  assign on_lv  = half ? LV_SEL_N : LV_SEL;
  assign off_lv = half ? LV_NSEL_N : LV_NSEL;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g < NKEY) begin : g_key
      assign seg_d[g] = blank ? LV_OFF : key_scan ? LV_YIELD :
                        (shadow[g] ? on_lv : off_lv);
    end else if (g >= NSEG - NLED) begin : g_led
      assign seg_d[g] = blank ? LV_OFF :
                        !lcd_mode ? (shadow[g] ? LV_OFF : LV_LED_ON) :
                        (shadow[g] ? on_lv : off_lv);
    end else begin : g_lcd
      assign seg_d[g] = blank ? LV_OFF : (shadow[g] ? on_lv : off_lv);
    end
  end

  for (genvar g = 0; g < NROW; g++) begin : g_com
    localparam logic [ROWW-1:0] GI = ROWW'(g);
    assign com_d[g] = blank ? LV_OFF : (row == GI) ? on_lv : off_lv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q <= '0;
      com_q <= '0;
    end else begin
      for (int j = 0; j < NSEG; j++) seg_q[j*LVW +: LVW] <= seg_d[j];
      for (int i = 0; i < NROW; i++) com_q[i*LVW +: LVW] <= com_d[i];
    end
  end

  logic [NROW-1:0] sel_flag;
  for (genvar g = 0; g < NROW; g++) begin : g_flag
    assign sel_flag[g] = (com_q[g*LVW +: LVW] == LV_SEL) ||
                         (com_q[g*LVW +: LVW] == LV_SEL_N);
  end

  // R7: blanking forces every output code to 0
  a_r7_blank_all_off: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (seg_q == '0 && com_q == '0));
  // R4: exactly one common is selected while scanning and enabled
  a_r4_one_selected: assert property (@(posedge clk) disable iff (rst)
    (running && out_en) |=> $countones(sel_flag) == 1);
endmodule

// File: rtl/lcd_scan_drv.sv
module lcd_scan_drv
  import lcd_pkg::*;
#(
  parameter int NSEG = 56,
  parameter int NROW = 4,
  parameter int NLED = 8,
  parameter int NKEY = 8,
  localparam int ROWW = $clog2(NROW)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ROWW-1:0]     wr_addr,
  input  logic [NSEG-1:0]     wr_data,
  input  logic [1:0]          duty_sel,
  input  logic                lcd_mode,
  input  logic                out_en,
  input  logic                key_scan,
  input  logic                tick,
  output logic [NSEG*LVW-1:0] seg_lv,
  output logic [NROW*LVW-1:0] com_lv
);
  logic            running, half, ld_en;
  logic [ROWW-1:0] row, ld_addr;
  logic [NSEG-1:0] shadow;

  lcd_row_seq #(.NROW(NROW)) i_seq (
    .clk(clk), .rst(rst), .tick(tick), .duty_sel(duty_sel),
    .running(running), .half(half), .row(row),
    .ld_en(ld_en), .ld_addr(ld_addr)
  );

  lcd_latch_bank #(.NSEG(NSEG), .NROW(NROW)) i_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ld_en(ld_en), .ld_addr(ld_addr), .shadow(shadow)
  );

  lcd_out_stage #(.NSEG(NSEG), .NROW(NROW), .NLED(NLED), .NKEY(NKEY)) i_out (
    .clk(clk), .rst(rst), .running(running), .half(half), .row(row),
    .shadow(shadow), .out_en(out_en), .lcd_mode(lcd_mode),
    .key_scan(key_scan), .seg_q(seg_lv), .com_q(com_lv)
  );
endmodule

// File: tb/test_lcd_scan_drv.sv
`timescale 1ns/1ps
module test_lcd_scan_drv;
  logic clk = 0, rst = 1;
  logic wr_en = 0, lcd_mode = 1, out_en = 1, key_scan = 0, tick = 0;
  logic [1:0] wr_addr = 0, duty_sel = 2'b11;
  logic [55:0] wr_data = 0;
  logic [167:0] seg_lv;
  logic [11:0] com_lv;

  lcd_scan_drv i_lcd_scan_drv (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .duty_sel(duty_sel), .lcd_mode(lcd_mode), .out_en(out_en),
    .key_scan(key_scan), .tick(tick), .seg_lv(seg_lv), .com_lv(com_lv)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  string cur_req = "R10";
  bit done = 0;

  // behavioural reference model
  logic [55:0] m_mem [4];
  logic [55:0] m_sh;
  int m_row, m_last, m_half, m_run;
  logic [167:0] exp_seg;
  logic [11:0] exp_com;

  function automatic int rows_for(logic [1:0] d);
    if (d == 2'b01) return 1;
    if (d == 2'b10) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) m_mem[i] = '0;
      m_sh = '0; m_row = 0; m_last = 3; m_half = 0; m_run = 0;
      exp_seg = '0; exp_com = '0;
    end else begin
      logic [55:0] nsh;
      bit blank;
      int on_c, off_c;
      blank = !out_en || !m_run;
      on_c  = m_half ? 2 : 1;
      off_c = m_half ? 4 : 3;
      for (int i = 0; i < 4; i++)
        exp_com[i*3 +: 3] = blank ? 3'd0 : (i == m_row ? 3'(on_c) : 3'(off_c));
      for (int j = 0; j < 56; j++) begin
        int c;
        if (blank) c = 0;
        else if (j < 8 && key_scan) c = 5;
        else if (j >= 48 && !lcd_mode) c = m_sh[j] ? 0 : 6;
        else c = m_sh[j] ? on_c : off_c;
        exp_seg[j*3 +: 3] = 3'(c);
      end
      nsh = m_sh;
      if (tick) begin
        if (!m_run) begin
          m_run = 1; m_row = 0; m_half = 0; nsh = m_mem[0];
          m_last = rows_for(duty_sel);
        end else if (m_half == 0) begin
          m_half = 1;
        end else begin
          m_half = 0;
          if (m_row == m_last) begin
            m_row = 0; m_last = rows_for(duty_sel);
          end else m_row = m_row + 1;
          nsh = m_mem[m_row];
        end
      end
      if (wr_en) m_mem[wr_addr] = wr_data;
      m_sh = nsh;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_run++;
      if (seg_lv !== exp_seg || com_lv !== exp_com) begin
        n_fail++;
        $display("FAIL %s: seg=%h com=%h expected seg=%h com=%h",
                 cur_req, seg_lv, com_lv, exp_seg, exp_com);
      end
    end
  end

  task automatic ticks(int n, int gap);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [55:0] d);
    @(negedge clk) begin wr_en = 1; wr_addr = a; wr_data = d; end
    @(negedge clk) wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R10";
    repeat (4) @(negedge clk);
    n_run++;
    if (seg_lv !== '0 || com_lv !== '0) begin
      n_fail++;
      $display("FAIL R10: outputs before first tick seg=%h com=%h expected 0", seg_lv, com_lv);
    end
    cur_req = "R1";
    wr(2'd0, 56'hA5_0000_0000_00F1);
    wr(2'd1, 56'h0F_1234_5678_9A3C);
    wr(2'd2, 56'hFF_FFFF_FFFF_FF00);
    wr(2'd3, 56'h81_8000_0000_0181);
    cur_req = "R4_R5";
    ticks(12, 2);
    cur_req = "R2";
    duty_sel = 2'b01;
    ticks(3, 1);
    ticks(12, 0);
    duty_sel = 2'b10;
    ticks(14, 1);
    cur_req = "R6";
    lcd_mode = 0;
    ticks(8, 1);
    lcd_mode = 1;
    cur_req = "R8";
    key_scan = 1;
    ticks(6, 1);
    key_scan = 0;
    cur_req = "R7";
    out_en = 0;
    ticks(5, 1);
    out_en = 1;
    ticks(8, 1);
    cur_req = "R9";
    duty_sel = 2'b11;
    ticks(1, 2);
    wr(2'd0, 56'h3C_C3C3_C3C3_C3C3);
    wr(2'd1, 56'h00_0000_0000_0001);
    ticks(10, 1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk) begin
        tick = 1; wr_en = 1; wr_addr = 2'(k); wr_data = {7{8'(k * 37 + 5)}};
      end
    end
    @(negedge clk) begin tick = 0; wr_en = 0; end
    cur_req = "R3";
    duty_sel = 2'b00;
    ticks(20, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule